// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between the load/store stage of a 32-bit datapath and a memory that is read and written one whole word at a time. On the store side it takes the source register value, the access size and the two low address bits. It produces the word to place on the memory write bus and a per-byte write-enable mask. On the load side it takes the word returned by memory and picks out the addressed byte or halfword. It then widens that value to 32 bits, with a sign fill or a zero fill chosen by a signedness input.

Byte lanes follow big-endian order. Address offset 0 is the most significant byte of the word. Each address names one 8-bit byte. Any access that breaks the alignment rules raises a misalign flag, and the block then drives neither a write nor a loaded value. The outputs can be taken straight from the combinational logic, or through one register stage chosen by a parameter (the default is registered).

Top module: `be_mem_lane_align`

## Requirements
- R1: The byte lane at address offset k (0 to 3) is bits [31-8k : 24-8k] of the memory word. A byte load returns the lane selected by `addr_ofs`.
- R2: When `ld_signed` is 1, a byte load or halfword load copies the top bit of the selected value into every higher bit of `ld_data`.
- R3: When `ld_signed` is 0, a byte load or halfword load fills every bit of `ld_data` above the selected value with zeros.
- R4: A halfword load at offset 0 returns bits [31:16] of the memory word, and at offset 2 it returns bits [15:0].
- R5: An aligned word load returns the memory word unchanged.
- R6: `wr_data` carries the low 8 bits of `st_data` in all four lanes for a byte access, and the low 16 bits in both halves for a halfword access. For a word access or the reserved size code, `st_data` is passed through unchanged.
- R7: The size encoding is 00 byte, 01 halfword, 10 word and 11 reserved. `wr_be[3]` enables lane 0 and `wr_be[0]` enables lane 3. An aligned store gives mask 1111 for a word. A halfword gives 1100 at offset 0 and 0011 at offset 2. A byte gives a single set bit, 1000 >> offset.
- R8: `misalign` is 1 in three cases: a halfword access with offset bit 0 set, a word access with a nonzero offset, or any access using the reserved size code. Otherwise it is 0.
- R9: When `misalign` is 1, `wr_be` is 0000 and `ld_data` is zero.
- R10: When `st_en` is 0, `wr_be` is 0000.
- R11: With `REG_OUT`=1, every output shows the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_size | input | 2 | Access size code (00 byte, 01 half, 10 word, 11 reserved) |
| addr_ofs | input | 2 | Low two bits of the byte address |
| ld_signed | input | 1 | 1 selects sign fill and 0 selects zero fill for narrow loads |
| st_en | input | 1 | The access is a store |
| st_data | input | 32 | Store source register value |
| rd_word | input | 32 | Word read from memory |
| wr_data | output | 32 | Word for the memory write bus |
| wr_be | output | 4 | Byte write enables, bit 3 for lane 0 |
| ld_data | output | 32 | Aligned and extended load result |
| misalign | output | 1 | The access breaks the alignment rules |

## Verification
The store path and the load path work from the same size and offset in the same cycle. The alignment check also gates both paths at once. So a single vector can produce a write mask, a replicated write word, an extended load value and a misalign decision together. The bench provokes this by driving `st_data` and `rd_word` with different patterns on every vector, while it sweeps every size code, offset, signedness and store flag, and then adds pseudo-random vectors. A behavioural model delays its expectation by the register latency. Each output is judged against that model separately, so that a wrong lane, a wrong mask or a wrong fill is traced to its own requirement.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/be_align_check.sv
module be_align_check
  import be_lane_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misalign
);
  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ofs[0];
      SZ_WORD: misalign = (ofs != '0);
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              st_en,
  input  logic              misalign,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);
  logic write_ok;
  assign write_ok = st_en & ~misalign;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * k;
    localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(k);
    logic [7:0] lane_byte;
    logic       hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: lane_byte = src[7:0];
        SZ_HALF: lane_byte = (k % 2 == 0) ? src[15:8] : src[7:0];
        default: lane_byte = src[HI -: 8];
      endcase
    end

    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (ofs == LANE_IDX);
        SZ_HALF: hit = (ofs[OFS_W-1:1] == LANE_IDX[OFS_W-1:1]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end

    assign wdata[HI -: 8]  = lane_byte;
    assign be[LANES-1-k]   = write_ok & hit;
  end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              sgn,
  input  logic              misalign,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [7:0] lanes [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign lanes[k] = word[DATA_W-1-8*k -: 8];
  end

  logic [OFS_W-1:0] half_lo_idx, half_hi_idx;
  logic [7:0]       sel_byte;
  logic [15:0]      sel_half;

  assign half_hi_idx = {ofs[OFS_W-1:1], 1'b0};
  assign half_lo_idx = {ofs[OFS_W-1:1], 1'b1};
  assign sel_byte    = lanes[ofs];
  assign sel_half    = {lanes[half_hi_idx], lanes[half_lo_idx]};

  always_comb begin
    if (misalign) begin
      result = '0;
    end else begin
      unique case (size)
        SZ_BYTE: result = {{(DATA_W-8){sgn & sel_byte[7]}}, sel_byte};
        SZ_HALF: result = {{(DATA_W-16){sgn & sel_half[15]}}, sel_half};
        default: result = word;
      endcase
    end
  end
endmodule

// File: rtl/be_mem_lane_align.sv
module be_mem_lane_align
  import be_lane_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_size,
  input  logic [OFS_W-1:0]  addr_ofs,
  input  logic              ld_signed,
  input  logic              st_en,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign
);
  acc_size_e size_c;
  assign size_c = acc_size_e'(acc_size);

  logic              mis_nx;
  logic [DATA_W-1:0] wdata_nx;
  logic [LANES-1:0]  be_nx;
  logic [DATA_W-1:0] ld_nx;

  be_align_check #(.OFS_W(OFS_W)) u_chk_align (
    .size     (size_c),
    .ofs      (addr_ofs),
    .misalign (mis_nx)
  );

  be_store_lanes #(.DATA_W(DATA_W)) u_store (
    .size     (size_c),
    .ofs      (addr_ofs),
    .st_en    (st_en),
    .misalign (mis_nx),
    .src      (st_data),
    .wdata    (wdata_nx),
    .be       (be_nx)
  );

  be_load_extract #(.DATA_W(DATA_W)) u_load (
    .size     (size_c),
    .ofs      (addr_ofs),
    .sgn      (ld_signed),
    .misalign (mis_nx),
    .word     (rd_word),
    .result   (ld_nx)
  );

  if (REG_OUT) begin : g_reg
    logic              mis_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] ld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mis_q   <= 1'b0;
        wdata_q <= '0;
        be_q    <= '0;
        ld_q    <= '0;
      end else begin
        mis_q   <= mis_nx;
        wdata_q <= wdata_nx;
        be_q    <= be_nx;
        ld_q    <= ld_nx;
      end
    end

    assign misalign = mis_q;
    assign wr_data  = wdata_q;
    assign wr_be    = be_q;
    assign ld_data  = ld_q;
  end else begin : g_comb
    assign misalign = mis_nx;
    assign wr_data  = wdata_nx;
    assign wr_be    = be_nx;
    assign ld_data  = ld_nx;
  end
endmodule

// File: rtl/be_mem_lane_align_chk.sv
module be_mem_lane_align_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        acc_size,
  input logic [OFS_W-1:0]  addr_ofs,
  input logic              ld_signed,
  input logic              st_en,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] wr_data,
  input logic [LANES-1:0]  wr_be,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign
);
  logic              vld;
  logic [1:0]        d_size;
  logic [OFS_W-1:0]  d_ofs;
  logic              d_sgn, d_st;
  logic [DATA_W-1:0] d_rd;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= 1'b0; d_size <= '0; d_ofs <= '0;
        d_sgn <= 1'b0; d_st <= 1'b0; d_rd <= '0;
      end else begin
        vld <= 1'b1; d_size <= acc_size; d_ofs <= addr_ofs;
        d_sgn <= ld_signed; d_st <= st_en; d_rd <= rd_word;
      end
    end
  end else begin : g_nodly
    assign vld = 1'b1;   assign d_size = acc_size; assign d_ofs = addr_ofs;
    assign d_sgn = ld_signed; assign d_st = st_en; assign d_rd = rd_word;
  end

  p_mis_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (wr_be == '0 && ld_data == '0));

  p_mask_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_be) == 0 || $countones(wr_be) == 1 || wr_be == 4'b1100 ||
     wr_be == 4'b0011 || wr_be == 4'b1111));

  p_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !d_st) |-> (wr_be == '0));

  p_byte_repl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_be) == 1) |->
      (wr_data[31:24] == wr_data[7:0] && wr_data[23:16] == wr_data[7:0] &&
       wr_data[15:8] == wr_data[7:0]));

  p_sign_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && d_sgn && d_size == 2'b00 && !misalign) |->
      (ld_data[31:8] == {24{ld_data[7]}}));

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !d_sgn && d_size == 2'b01 && !misalign) |-> (ld_data[31:16] == '0));

  p_word_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && d_size == 2'b10 && d_ofs == '0) |-> (ld_data == d_rd));
endmodule

bind be_mem_lane_align be_mem_lane_align_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_lane_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_size  (acc_size),
  .addr_ofs  (addr_ofs),
  .ld_signed (ld_signed),
  .st_en     (st_en),
  .rd_word   (rd_word),
  .wr_data   (wr_data),
  .wr_be     (wr_be),
  .ld_data   (ld_data),
  .misalign  (misalign)
);

// File: tb/be_mem_lane_align_bench.sv
module be_mem_lane_align_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  acc_size;
  logic [1:0]  addr_ofs;
  logic        ld_signed, st_en;
  logic [31:0] st_data, rd_word;
  logic [31:0] wr_data, ld_data;
  logic [3:0]  wr_be;
  logic        misalign;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  be_mem_lane_align u_be_mem_lane_align (
    .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .addr_ofs(addr_ofs),
    .ld_signed(ld_signed), .st_en(st_en), .st_data(st_data), .rd_word(rd_word),
    .wr_data(wr_data), .wr_be(wr_be), .ld_data(ld_data), .misalign(misalign)
  );

  typedef struct {
    logic [31:0] wd; logic [3:0] be; logic [31:0] ld; logic mis;
    string ld_tag; string be_tag;
  } exp_t;

  exp_t pend[$];

  function automatic exp_t model(int sz, int ofs, bit sgn, bit st,
                                 logic [31:0] src, logic [31:0] rd);
    exp_t e;
    int b, h;
    e.mis = (sz == 3) || (sz == 2 && ofs != 0) || (sz == 1 && ofs % 2 == 1);
    if (sz == 0)      e.wd = {4{src[7:0]}};
    else if (sz == 1) e.wd = {2{src[15:0]}};
    else              e.wd = src;
    if (!st || e.mis) e.be = 4'b0000;
    else if (sz == 2) e.be = 4'b1111;
    else if (sz == 1) e.be = (ofs == 0) ? 4'b1100 : 4'b0011;
    else              e.be = 4'(8 >> ofs);
    e.be_tag = e.mis ? "R9" : (!st ? "R10" : "R7");
    b = (rd >> (8 * (3 - ofs))) & 8'hFF;
    h = (ofs < 2) ? (rd >> 16) : (rd & 16'hFFFF);
    if (e.mis) begin
      e.ld = 0; e.ld_tag = "R9";
    end else if (sz == 0) begin
      e.ld = (sgn && b >= 128) ? 32'(b - 256) : 32'(b);
      e.ld_tag = sgn ? "R1,R2" : "R1,R3";
    end else if (sz == 1) begin
      e.ld = (sgn && h >= 32768) ? 32'(h - 65536) : 32'(h);
      e.ld_tag = sgn ? "R4,R2" : "R4,R3";
    end else begin
      e.ld = rd; e.ld_tag = "R5";
    end
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_vec++;
    if (misalign !== e.mis) begin
      n_bad++; $display("FAIL R8 misalign act=%0b exp=%0b", misalign, e.mis);
    end
    if (wr_be !== e.be) begin
      n_bad++; $display("FAIL %s wr_be act=%b exp=%b", e.be_tag, wr_be, e.be);
    end
    if (wr_data !== e.wd) begin
      n_bad++; $display("FAIL R6 wr_data act=%h exp=%h", wr_data, e.wd);
    end
    if (ld_data !== e.ld) begin
      n_bad++; $display("FAIL %s ld_data act=%h exp=%h", e.ld_tag, ld_data, e.ld);
    end
  endtask

  // One vector per cycle: compare previous expectation (R11 latency), then drive.
  task automatic apply(int sz, int ofs, bit sgn, bit st, logic [31:0] src, logic [31:0] rd);
    @(negedge clk);
    if (pend.size() > 0) compare(pend.pop_front());
    acc_size = 2'(sz); addr_ofs = 2'(ofs); ld_signed = sgn; st_en = st;
    st_data = src; rd_word = rd;
    pend.push_back(model(sz, ofs, sgn, st, src, rd));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pat_src [4];
    logic [31:0] pat_rd  [4];
    logic [31:0] lfsr;
    pat_src = '{32'h1234_5678, 32'hCAFE_F00D, 32'h0000_0080, 32'hFFFF_7F01};
    pat_rd  = '{32'h80FF_017F, 32'h8899_AABB, 32'h7F80_8001, 32'h0011_2233};
    rst_n = 1'b0; acc_size = 0; addr_ofs = 0; ld_signed = 0; st_en = 1;
    st_data = 32'hDEAD_BEEF; rd_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero while reset is low despite live inputs
    n_vec++;
    if (wr_data !== 0 || wr_be !== 0 || ld_data !== 0 || misalign !== 0) begin
      n_bad++;
      $display("FAIL R11 reset outputs act=%h/%b/%h/%b exp=0/0/0/0",
               wr_data, wr_be, ld_data, misalign);
    end
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int ofs = 0; ofs < 4; ofs++)
          for (int s = 0; s < 2; s++)
            for (int st = 0; st < 2; st++)
              apply(sz, ofs, s[0], st[0], pat_src[p], pat_rd[(p + sz) % 4]);
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5; a = lfsr;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5; b = lfsr;
      apply(int'(a[1:0]), int'(a[3:2]), a[4], a[5], a, b);
    end
    @(negedge clk);
    if (pend.size() > 0) compare(pend.pop_front());
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule